// File: doc/BRIEF.md
# Slave Register Access Cycle Controller

This block runs the slave side of a register access on a peripheral that can also be a bus master. An external host selects the device with an active-low chip select, frames each access with an active-low address strobe, and gives a read/write line and a register address. The block answers with an active-low slave acknowledge, then with a pair of active-low termination strobes. It drives the output half of a tri-state data bus through an output enable. Toward the register file it presents an address, a write strobe with write data, and it takes combinational read data back.

The chip select may arrive while the device is running a master cycle of its own. In that case the block raises a yield request so that the master engine finishes its cycle and gives up the bus. The acknowledge then arrives after a longer fixed delay, extended by one clock for each wait state that the master engine reports. Chip select and the separate memory-request select are each brought into the clock domain through a two-flop synchronizer. A guard flags a protocol error when the two selects overlap or sit too close together.

Top module: `rac_ctrl`

## Requirements
- R1: While reset is low and after it is released with no access, slv_ack_n is 1, term_n is 2'b11, dbus_oe is 0, reg_we is 0, yield_req is 0 and prot_err is 0.
- R2: An access starts only when the synchronized chip select and the address strobe are both low. With sel_n held low and strb_n high, slv_ack_n stays 1.
- R3: When master_busy is 0 at the start, slv_ack_n goes low after the third rising clock edge that follows sel_n and strb_n both going low at the ports (two synchronizer stages plus one).
- R4: When master_busy is 1 at the start, yield_req is 1 while the block waits, and slv_ack_n goes low after the seventh rising edge that follows sel_n and strb_n going low, plus one edge for each clock in which master_wait is 1 during the wait. yield_req and slv_ack_n are never both asserted.
- R5: On a read (rd_wr = 1), dbus_out takes reg_rdata for the captured address on the same edge that lowers slv_ack_n, dbus_oe is 1 while slv_ack_n is low, and dbus_out holds steady while the acknowledge stays low.
- R6: On a write (rd_wr = 0), dbus_in is latched on the second rising edge after the edge that lowered slv_ack_n. reg_we is 1 for the one following clock, with reg_wdata holding the latched value and reg_addr_o the captured address.
- R7: Both bits of term_n (both low means a 16-bit port) go low on the second rising edge after the edge that lowered slv_ack_n.
- R8: The acknowledge, term_n and dbus_oe are released on the first edge at which strb_n is high, or once a rising chip select has passed the synchronizer, whichever comes first.
- R9: When chip select stays low between accesses, a new strobe fall starts the next access, and slv_ack_n goes low after the first rising edge that follows it.
- R10: prot_err is raised when the synchronized chip select and memory select are low at the same time.
- R11: prot_err is raised when the memory select goes low less than two clocks after chip select went high. At two clocks or more it stays 0.
- R12: A strobe that rises while the block waits for the master cycle cancels the access: no acknowledge and no write follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Chip select, active low, asynchronous |
| strb_n | input | 1 | Address strobe, active low, synchronous |
| rd_wr | input | 1 | 1 = read, 0 = write |
| reg_addr | input | AW | Register address from the host |
| mem_sel_n | input | 1 | Memory-request select, active low, asynchronous |
| master_busy | input | 1 | Device is running a master cycle |
| master_wait | input | 1 | Current master cycle is in a wait state |
| dbus_in | input | DW | Data bus, input half |
| dbus_out | output | DW | Data bus, output half |
| dbus_oe | output | 1 | Output enable for the data bus drivers |
| slv_ack_n | output | 1 | Slave acknowledge, active low |
| term_n | output | 2 | Termination strobes, active low |
| yield_req | output | 1 | Request to the master engine to finish and release the bus |
| reg_addr_o | output | AW | Address to the register file |
| reg_rdata | input | DW | Combinational read data from the register file |
| reg_wdata | output | DW | Latched write data |
| reg_we | output | 1 | Register write strobe, one clock |
| prot_err | output | 1 | Select overlap or spacing violation |

## Verification
The bench puts the wrong write data on the bus in every clock but the one that the latch edge samples. A latch one clock early or late therefore shows up as corrupted reg_wdata. It runs acknowledges with and without master ownership and with several wait-state counts, so a design that drops the extra delay or ignores wait states acknowledges on the wrong clock. It releases some accesses by strobe and some by chip select. It holds chip select low across accesses, so a design that needs a fresh select, or that lets select alone start a cycle, produces a missing or unexpected acknowledge. It also aborts an access during the yield and places the memory select one and two clocks after chip select, which separates a correct guard window from an off-by-one.

// File: rtl/rac_pkg.sv
package rac_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_YIELD = 2'd1,
    ST_ACK   = 2'd2,
    ST_TERM  = 2'd3
  } rac_state_e;
endpackage

// File: rtl/rac_sync.sv
module rac_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_n,
  output logic q_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {STAGES{1'b1}};
    else        sh_q <= sh_d;
  end

  assign q_n = sh_q[STAGES-1];
endmodule

// File: rtl/rac_seq.sv
module rac_seq
  import rac_pkg::*;
#(
  parameter int YIELD_LAT = 5,
  parameter int TERM_LAT  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_s_n,
  input  logic       strb_n,
  input  logic       rd_wr,
  input  logic       master_busy,
  input  logic       master_wait,
  output rac_state_e state,
  output logic       rd_q,
  output logic       cap,
  output logic       rd_load,
  output logic       wr_latch
);
  localparam int CMAX = (YIELD_LAT > TERM_LAT) ? YIELD_LAT : TERM_LAT;
  localparam int CW   = $clog2(CMAX + 1);

  rac_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rd_d;
  logic          release_c;

  assign release_c = strb_n | sel_s_n;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    rd_d     = rd_q;
    cap      = 1'b0;
    rd_load  = 1'b0;
    wr_latch = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (!sel_s_n && !strb_n) begin
          cap  = 1'b1;
          rd_d = rd_wr;
          if (master_busy) begin
            state_d = ST_YIELD;
            cnt_d   = CW'(YIELD_LAT - 2);
          end else begin
            state_d = ST_ACK;
            cnt_d   = CW'(TERM_LAT - 1);
            rd_load = rd_wr;
          end
        end
      end
      ST_YIELD: begin
        if (release_c) begin
          state_d = ST_IDLE;
        end else if (!master_wait) begin
          if (cnt_q == '0) begin
            state_d = ST_ACK;
            cnt_d   = CW'(TERM_LAT - 1);
            rd_load = rd_q;
          end else begin
            cnt_d = cnt_q - CW'(1);
          end
        end
      end
      ST_ACK: begin
        if (release_c) begin
          state_d = ST_IDLE;
        end else if (cnt_q == '0) begin
          state_d  = ST_TERM;
          wr_latch = !rd_q;
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      ST_TERM: begin
        if (release_c) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rd_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (cap) rd_q <= rd_d;
    end
  end

  assign state = state_q;
endmodule

// File: rtl/rac_dpath.sv
module rac_dpath #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idle,
  input  logic          cap,
  input  logic          rd_load,
  input  logic          wr_latch,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_rdata,
  input  logic [DW-1:0] dbus_in,
  output logic [AW-1:0] reg_addr_o,
  output logic [DW-1:0] dbus_out,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_we
);
  logic [AW-1:0] addr_q;
  logic [DW-1:0] rdat_q;
  logic [DW-1:0] wdat_q;
  logic          we_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rdat_q <= '0;
      wdat_q <= '0;
      we_q   <= 1'b0;
    end else begin
      if (cap)      addr_q <= reg_addr;
      if (rd_load)  rdat_q <= reg_rdata;
      if (wr_latch) wdat_q <= dbus_in;
      we_q <= wr_latch;
    end
  end

  assign reg_addr_o = idle ? reg_addr : addr_q;
  assign dbus_out   = rdat_q;
  assign reg_wdata  = wdat_q;
  assign reg_we     = we_q;
endmodule

// File: rtl/rac_guard.sv
module rac_guard #(
  parameter int GUARD_CLKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_s_n,
  input  logic mem_s_n,
  output logic prot_err
);
  localparam int GW = $clog2(GUARD_CLKS + 1);

  logic [GW-1:0] guard_q, guard_d;
  logic          err_q, err_d;

  always_comb begin
    if (!sel_s_n)            guard_d = GW'(GUARD_CLKS);
    else if (guard_q != '0)  guard_d = guard_q - GW'(1);
    else                     guard_d = guard_q;
    err_d = !mem_s_n && (!sel_s_n || (guard_q != '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      guard_q <= '0;
      err_q   <= 1'b0;
    end else begin
      guard_q <= guard_d;
      err_q   <= err_d;
    end
  end

  assign prot_err = err_q;
endmodule

// File: rtl/rac_ctrl.sv
module rac_ctrl
  import rac_pkg::*;
#(
  parameter int AW          = 6,
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2,
  parameter int YIELD_LAT   = 5,
  parameter int TERM_LAT    = 2,
  parameter int GUARD_CLKS  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_n,
  input  logic          strb_n,
  input  logic          rd_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic          mem_sel_n,
  input  logic          master_busy,
  input  logic          master_wait,
  input  logic [DW-1:0] dbus_in,
  output logic [DW-1:0] dbus_out,
  output logic          dbus_oe,
  output logic          slv_ack_n,
  output logic [1:0]    term_n,
  output logic          yield_req,
  output logic [AW-1:0] reg_addr_o,
  input  logic [DW-1:0] reg_rdata,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_we,
  output logic          prot_err
);
  localparam int NSYNC = 2;

  logic [NSYNC-1:0] raw_n;
  logic [NSYNC-1:0] syn_n;
  rac_state_e       state;
  logic             rd_q, cap, rd_load, wr_latch;
  logic             acking;

  assign raw_n = {mem_sel_n, sel_n};

  for (genvar g = 0; g < NSYNC; g++) begin : g_sync
    rac_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_n  (raw_n[g]),
      .q_n  (syn_n[g])
    );
  end

  rac_seq #(.YIELD_LAT(YIELD_LAT), .TERM_LAT(TERM_LAT)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_s_n    (syn_n[0]),
    .strb_n     (strb_n),
    .rd_wr      (rd_wr),
    .master_busy(master_busy),
    .master_wait(master_wait),
    .state      (state),
    .rd_q       (rd_q),
    .cap        (cap),
    .rd_load    (rd_load),
    .wr_latch   (wr_latch)
  );

  rac_dpath #(.AW(AW), .DW(DW)) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .idle      (state == ST_IDLE),
    .cap       (cap),
    .rd_load   (rd_load),
    .wr_latch  (wr_latch),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .dbus_in   (dbus_in),
    .reg_addr_o(reg_addr_o),
    .dbus_out  (dbus_out),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we)
  );

  rac_guard #(.GUARD_CLKS(GUARD_CLKS)) u_guard (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_s_n (syn_n[0]),
    .mem_s_n (syn_n[1]),
    .prot_err(prot_err)
  );

  assign acking    = (state == ST_ACK) || (state == ST_TERM);
  assign slv_ack_n = !acking;
  assign term_n    = {2{state != ST_TERM}};
  assign dbus_oe   = acking && rd_q;
  assign yield_req = (state == ST_YIELD);
endmodule

// File: rtl/rac_ctrl_chk.sv
module rac_ctrl_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          strb_n,
  input logic          slv_ack_n,
  input logic [1:0]    term_n,
  input logic          dbus_oe,
  input logic [DW-1:0] dbus_out,
  input logic          reg_we,
  input logic          yield_req
);
  // R4
  yield_ack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(yield_req && !slv_ack_n));

  // R5
  oe_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbus_oe |-> !slv_ack_n);

  // R5
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!slv_ack_n && !$past(slv_ack_n)) |-> $stable(dbus_out));

  // R6
  we_in_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (term_n == 2'b00));

  // R7
  term_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(term_n[0]) |-> (!$past(slv_ack_n) && !$past(slv_ack_n, 2)));

  // R8
  strobe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb_n |=> (slv_ack_n && term_n == 2'b11));
endmodule

bind rac_ctrl rac_ctrl_chk #(.DW(DW)) i_rac_ctrl_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .strb_n   (strb_n),
  .slv_ack_n(slv_ack_n),
  .term_n   (term_n),
  .dbus_oe  (dbus_oe),
  .dbus_out (dbus_out),
  .reg_we   (reg_we),
  .yield_req(yield_req)
);

// File: tb/test_rac_ctrl.sv
module test_rac_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DW = 16;

  logic          clk, rst_n;
  logic          sel_n, strb_n, rd_wr, mem_sel_n, master_busy, master_wait;
  logic [AW-1:0] reg_addr, reg_addr_o;
  logic [DW-1:0] dbus_in, dbus_out, reg_rdata, reg_wdata;
  logic          dbus_oe, slv_ack_n, yield_req, reg_we, prot_err;
  logic [1:0]    term_n;

  int cyc = 0;
  int n_checks = 0;
  int n_errors = 0;
  int ack_seen = 0;
  int we_seen = 0;
  bit finished = 0;

  typedef struct {
    int            ack_cyc;
    bit            rd;
    logic [DW-1:0] data;
    logic [AW-1:0] addr;
    string         tag;
  } item_t;

  item_t exp_q[$];
  item_t cur;

  function automatic logic [DW-1:0] rdf(input logic [AW-1:0] a);
    return 16'hC35A ^ {a, a[3:0], a};
  endfunction

  assign reg_rdata = rdf(reg_addr_o);

  rac_ctrl i_rac_ctrl (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .strb_n(strb_n), .rd_wr(rd_wr),
    .reg_addr(reg_addr), .mem_sel_n(mem_sel_n), .master_busy(master_busy),
    .master_wait(master_wait), .dbus_in(dbus_in), .dbus_out(dbus_out),
    .dbus_oe(dbus_oe), .slv_ack_n(slv_ack_n), .term_n(term_n),
    .yield_req(yield_req), .reg_addr_o(reg_addr_o), .reg_rdata(reg_rdata),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .prot_err(prot_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  // monitor: pops expected items as the design acknowledges
  logic prev_ack = 1'b1, prev_term = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_ack && !slv_ack_n) begin
        ack_seen++;
        if (exp_q.size() == 0) begin
          chk(0, "R12", "unexpected acknowledge", cyc, 0);
        end else begin
          cur = exp_q.pop_front();
          chk(cyc == cur.ack_cyc, cur.tag, "acknowledge cycle", cyc, cur.ack_cyc);
          if (cur.rd) begin
            // R5
            chk(dbus_oe == 1'b1, "R5", "read output enable", dbus_oe, 1);
            chk(dbus_out == rdf(cur.addr), "R5", "read data", dbus_out, rdf(cur.addr));
          end
        end
      end
      if (prev_term && term_n == 2'b00) begin
        // R7
        chk(cyc == cur.ack_cyc + 2, "R7", "terminator cycle", cyc, cur.ack_cyc + 2);
      end
      if (reg_we) begin
        we_seen++;
        // R6
        chk(!cur.rd, "R6", "write strobe on read", 1, 0);
        chk(cyc == cur.ack_cyc + 2, "R6", "write strobe cycle", cyc, cur.ack_cyc + 2);
        chk(reg_wdata == cur.data, "R6", "write data", reg_wdata, cur.data);
        chk(reg_addr_o == cur.addr, "R6", "write address", reg_addr_o, cur.addr);
      end
    end
    prev_ack  = slv_ack_n;
    prev_term = term_n[0];
  end

  task automatic access(input bit rd, input logic [AW-1:0] addr,
                        input logic [DW-1:0] wd, input bit mst, input int waits,
                        input bit keep_sel, input bit rel_sel, input string tag);
    item_t it;
    int c, s, a, we0;
    bit b2b;
    @(negedge clk);
    c   = cyc;
    b2b = (sel_n == 1'b0);
    we0 = we_seen;
    rd_wr = rd; reg_addr = addr; dbus_in = ~wd; master_busy = mst;
    sel_n = 1'b0; strb_n = 1'b0;
    s = c + (b2b ? 1 : 3);
    a = s + (mst ? 4 + waits : 0);
    it.ack_cyc = a; it.rd = rd; it.data = wd; it.addr = addr; it.tag = tag;
    exp_q.push_back(it);
    while (cyc < s) @(negedge clk);
    master_busy = 1'b0;
    if (mst) begin
      // R4
      chk(yield_req == 1'b1, "R4", "yield request", yield_req, 1);
    end
    if (waits > 0) begin
      master_wait = 1'b1;
      repeat (waits) @(negedge clk);
      master_wait = 1'b0;
    end
    while (cyc < a + 1) @(negedge clk);
    dbus_in = wd;
    @(negedge clk);
    dbus_in = ~wd;
    while (cyc < a + 4) @(negedge clk);
    chk(exp_q.size() == 0, tag, "missing acknowledge", exp_q.size(), 0);
    if (!rd) chk(we_seen == we0 + 1, "R6", "write strobe count", we_seen - we0, 1);
    if (rel_sel) begin
      sel_n = 1'b1;
      repeat (3) @(negedge clk);
      strb_n = 1'b1;
    end else begin
      strb_n = 1'b1;
      if (!keep_sel) sel_n = 1'b1;
      @(negedge clk);
    end
    // R8
    chk(slv_ack_n == 1'b1 && term_n == 2'b11 && dbus_oe == 1'b0, "R8",
        rel_sel ? "release by select" : "release by strobe",
        {slv_ack_n, term_n, dbus_oe}, 4'b1110);
    repeat (3) @(negedge clk);
  endtask

  task automatic poll_err(input int n, input bit expv, input string req);
    bit seen = 0;
    repeat (n) begin
      @(negedge clk);
      if (prot_err) seen = 1;
    end
    chk(seen == expv, req, "protocol error flag", seen, expv);
  endtask

  initial begin
    int acks0, we0;
    rst_n = 1'b0; sel_n = 1'b1; strb_n = 1'b1; rd_wr = 1'b1; reg_addr = '0;
    mem_sel_n = 1'b1; master_busy = 1'b0; master_wait = 1'b0; dbus_in = '0;
    repeat (3) @(negedge clk);
    // R1
    chk(slv_ack_n && term_n == 2'b11 && !dbus_oe && !reg_we && !yield_req && !prot_err,
        "R1", "outputs in reset", {slv_ack_n, term_n, dbus_oe, reg_we, yield_req, prot_err}, 7'b1110000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(slv_ack_n && term_n == 2'b11 && !dbus_oe && !reg_we && !yield_req && !prot_err,
        "R1", "outputs after reset", {slv_ack_n, term_n, dbus_oe, reg_we, yield_req, prot_err}, 7'b1110000);

    // R3 plain read and write
    access(1'b1, 6'h05, 16'h0000, 1'b0, 0, 1'b0, 1'b0, "R3");
    access(1'b0, 6'h12, 16'hBEEF, 1'b0, 0, 1'b0, 1'b0, "R3");
    // R4 master owned, with and without wait states
    access(1'b1, 6'h21, 16'h0000, 1'b1, 0, 1'b0, 1'b0, "R4");
    access(1'b0, 6'h2A, 16'h1357, 1'b1, 2, 1'b0, 1'b0, "R4");
    access(1'b1, 6'h3F, 16'h0000, 1'b1, 3, 1'b0, 1'b1, "R4");
    // R8 release by chip select on a write
    access(1'b0, 6'h09, 16'h55AA, 1'b0, 0, 1'b0, 1'b1, "R3");

    // R2 select alone does not start a cycle
    @(negedge clk);
    sel_n = 1'b0;
    acks0 = ack_seen;
    repeat (8) @(negedge clk);
    chk(ack_seen == acks0 && slv_ack_n, "R2", "ack with select only", ack_seen - acks0, 0);
    // R9 back-to-back under a held select
    access(1'b1, 6'h0C, 16'h0000, 1'b0, 0, 1'b1, 1'b0, "R9");
    access(1'b0, 6'h33, 16'hA5C3, 1'b0, 0, 1'b1, 1'b0, "R9");
    access(1'b0, 6'h34, 16'h0F0F, 1'b0, 0, 1'b0, 1'b0, "R9");

    // R12 abort during yield
    @(negedge clk);
    acks0 = ack_seen; we0 = we_seen;
    rd_wr = 1'b0; reg_addr = 6'h11; master_busy = 1'b1; sel_n = 1'b0; strb_n = 1'b0;
    repeat (5) @(negedge clk);
    master_busy = 1'b0; strb_n = 1'b1; sel_n = 1'b1;
    repeat (12) @(negedge clk);
    chk(ack_seen == acks0 && we_seen == we0, "R12", "abort left ack or write",
        (ack_seen - acks0) + (we_seen - we0), 0);

    // R10 overlapping selects
    sel_n = 1'b0; mem_sel_n = 1'b0;
    poll_err(5, 1'b1, "R10");
    sel_n = 1'b1; mem_sel_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(!prot_err, "R10", "flag clears", prot_err, 0);
    // R11 spacing of one clock
    sel_n = 1'b0;
    repeat (4) @(negedge clk);
    sel_n = 1'b1;
    @(negedge clk);
    mem_sel_n = 1'b0;
    poll_err(6, 1'b1, "R11");
    mem_sel_n = 1'b1;
    repeat (6) @(negedge clk);
    // R11 spacing of two clocks
    sel_n = 1'b0;
    repeat (4) @(negedge clk);
    sel_n = 1'b1;
    repeat (2) @(negedge clk);
    mem_sel_n = 1'b0;
    poll_err(6, 1'b0, "R11");
    mem_sel_n = 1'b1;
    repeat (4) @(negedge clk);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      chk(0, "R1", "watchdog expired", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule